// File: doc/BRIEF.md
# Snoop-Coherent Cache Tag Controller

This block holds the tag and line-state store of a small direct-mapped data cache. The cache stays coherent with other bus masters by snooping. Each line is in one of three states. Invalid holds nothing usable. Exclusive holds the only cached copy, and that copy still equals memory. Modified holds the only valid copy, and memory is stale. The block answers a processor port (load, store, line fill) and a bus snoop port (read or invalidate). For each access it reports a hit or miss, the need to write back, and a stall.

The tag store has a single port, so only one of the two sides can use it in a clock. A snoop always takes the store first. A processor access that collides with a snoop is stalled and must be held by the requester; it is served on the next clock that has no snoop. After reset the block sweeps every line to invalid, and it keeps its stall output high until the sweep is done. A miss changes nothing. The requester then issues a fill, and the fill installs the new tag.

Top module: `mei_tag_ctrl`

## Requirements
- R1: After reset is released, `stall` is high for exactly `2**IDX_W` clocks. No processor access is accepted in that time (`cpu_done` low). Afterwards every line is invalid, so any load misses.
- R2: `cpu_op` is encoded as 0 = load, 1 = store, 2 = fill for a load, 3 = fill for a store. A load or store reports `cpu_hit` only when the stored tag equals the address tag and the line is not invalid. A load never changes the line.
- R3: A fill for a load (op 2) installs the address tag in exclusive state. A fill for a store (op 3) installs it in modified state. Neither fill reports `cpu_hit`.
- R4: A store that hits an exclusive line makes it modified, with no bus action.
- R5: When `snp_valid` and `cpu_valid` are high in the same clock, the snoop uses the tag store, `stall` is high and `cpu_done` is low. The held processor request is served on the next clock without a snoop, and it sees the line as the snoop left it.
- R6: A snoop that hits a modified line raises `snp_wb` in that clock only. An invalidate (`snp_inv`=1) then leaves the line invalid. A read (`snp_inv`=0) leaves it exclusive.
- R7: A snoop that hits an exclusive line leaves it invalid, for both reads and invalidates, and does not raise `snp_wb`.
- R8: A snoop that misses raises neither `snp_hit` nor `snp_wb` and changes no line. A snoop during the reset sweep is answered (`snp_done`) as a miss.
- R9: A fill whose target line is modified raises `cpu_evict` in that clock. A fill whose target line is not modified does not raise it.
- R10: The line index is `addr[OFF_W +: IDX_W]` and the tag is the bits above it. The offset bits below the index do not affect a hit. Two addresses with the same index but different tags do not both hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present, held while `stall` |
| cpu_op | input | 2 | 0 load, 1 store, 2 fill-load, 3 fill-store |
| cpu_addr | input | ADDR_W | Processor byte address |
| snp_valid | input | 1 | Snoop request present |
| snp_inv | input | 1 | 1 = snoop invalidate, 0 = snoop read |
| snp_addr | input | ADDR_W | Snooped byte address |
| stall | output | 1 | Processor request not served this clock |
| cpu_done | output | 1 | Processor request served this clock |
| cpu_hit | output | 1 | Load/store hit |
| cpu_evict | output | 1 | Fill displaces a modified line |
| snp_done | output | 1 | Snoop answered this clock |
| snp_hit | output | 1 | Snoop found a valid matching line |
| snp_wb | output | 1 | Snooped line is modified and must be written back |

## Verification
The checker watches, on every clock, the rules that hold locally. A collision always stalls the processor. A write-back response only comes with a hit. The sweep blocks all processor service and all snoop hits. A processor request held through a collision is served once the snoop is gone. The state changes themselves are only visible across a series of accesses: exclusive becoming modified, a snoop read turning modified into exclusive and exclusive into invalid, and a fill over a dirty line. The bench's access sequences expose these, as does the collision case in which the held load misses because the snoop invalidated the line first.

// File: rtl/mei_pkg.sv
package mei_pkg;

   typedef enum logic [1:0] {
      LN_INV = 2'b00,
      LN_EXC = 2'b01,
      LN_MOD = 2'b10
   } line_st_t;

   typedef enum logic [1:0] {
      OP_LOAD    = 2'd0,
      OP_STORE   = 2'd1,
      OP_FILL_LD = 2'd2,
      OP_FILL_ST = 2'd3
   } cpu_op_t;

endpackage

// File: rtl/mei_clr_seq.sv
module mei_clr_seq #(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             busy,
   output logic [IDX_W-1:0] clr_idx
);
   localparam int SETS = 1 << IDX_W;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(SETS - 1);

   logic [IDX_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == LAST) busy_q <= 1'b0;
      end
   end

   assign busy    = busy_q;
   assign clr_idx = cnt_q;
endmodule

// File: rtl/mei_arb.sv
module mei_arb #(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 4,
   parameter int IDX_W  = 4
) (
   input  logic                          busy,
   input  logic                          cpu_valid,
   input  logic [ADDR_W-1:0]             cpu_addr,
   input  logic                          snp_valid,
   input  logic [ADDR_W-1:0]             snp_addr,
   output logic                          gnt_snp,
   output logic                          gnt_cpu,
   output logic [IDX_W-1:0]              acc_idx,
   output logic [ADDR_W-IDX_W-OFF_W-1:0] acc_tag
);
   localparam int TAG_LO = OFF_W + IDX_W;

   logic [ADDR_W-1:0] sel_addr;

   always_comb begin
      gnt_snp  = snp_valid & ~busy;
      gnt_cpu  = cpu_valid & ~busy & ~snp_valid;
      sel_addr = snp_valid ? snp_addr : cpu_addr;
      acc_idx  = sel_addr[OFF_W +: IDX_W];
      acc_tag  = sel_addr[ADDR_W-1:TAG_LO];
   end
endmodule

// File: rtl/mei_tag_store.sv
module mei_tag_store #(
   parameter int IDX_W = 4,
   parameter int TAG_W = 8
) (
   input  logic                 clk,
   input  logic                 we,
   input  logic [IDX_W-1:0]     idx,
   input  logic [TAG_W-1:0]     wr_tag,
   input  mei_pkg::line_st_t    wr_st,
   output logic [TAG_W-1:0]     rd_tag,
   output mei_pkg::line_st_t    rd_st
);
   localparam int SETS = 1 << IDX_W;

   logic [TAG_W-1:0]  tag_q [SETS];
   mei_pkg::line_st_t st_q  [SETS];

   for (genvar g = 0; g < SETS; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (we && (idx == IDX_W'(g))) begin
            tag_q[g] <= wr_tag;
            st_q[g]  <= wr_st;
         end
      end
   end

   assign rd_tag = tag_q[idx];
   assign rd_st  = st_q[idx];
endmodule

// File: rtl/mei_next_st.sv
module mei_next_st (
   input  logic              gnt_snp,
   input  logic              gnt_cpu,
   input  logic              snp_inv,
   input  mei_pkg::cpu_op_t  op,
   input  logic              match,
   input  mei_pkg::line_st_t cur,
   output logic              upd,
   output logic              new_tag,
   output mei_pkg::line_st_t nxt
);
   import mei_pkg::*;

   always_comb begin
      upd     = 1'b0;
      new_tag = 1'b0;
      nxt     = cur;
      if (gnt_snp) begin
         if (match) begin
            upd = 1'b1;
            if (snp_inv)            nxt = LN_INV;
            else if (cur == LN_MOD) nxt = LN_EXC;
            else                    nxt = LN_INV;
         end
      end else if (gnt_cpu) begin
         unique case (op)
            OP_LOAD: ;
            OP_STORE: begin
               if (match && cur == LN_EXC) begin
                  upd = 1'b1;
                  nxt = LN_MOD;
               end
            end
            OP_FILL_LD: begin
               upd = 1'b1; new_tag = 1'b1; nxt = LN_EXC;
            end
            OP_FILL_ST: begin
               upd = 1'b1; new_tag = 1'b1; nxt = LN_MOD;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mei_tag_ctrl.sv
module mei_tag_ctrl #(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 4,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic [1:0]        cpu_op,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              snp_valid,
   input  logic              snp_inv,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              stall,
   output logic              cpu_done,
   output logic              cpu_hit,
   output logic              cpu_evict,
   output logic              snp_done,
   output logic              snp_hit,
   output logic              snp_wb
);
   import mei_pkg::*;

   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

   if (TAG_W < 1) begin : g_bad_tag
      $error("mei_tag_ctrl: ADDR_W leaves no tag bits");
   end
   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("mei_tag_ctrl: IDX_W out of range 1..10");
   end

   logic             busy;
   logic [IDX_W-1:0] clr_idx;
   logic             gnt_snp, gnt_cpu;
   logic [IDX_W-1:0] acc_idx;
   logic [TAG_W-1:0] acc_tag;
   logic [TAG_W-1:0] rd_tag;
   line_st_t         rd_st;
   logic             match;
   logic             upd, new_tag;
   line_st_t         nxt;
   logic             st_we;
   logic [IDX_W-1:0] st_idx;
   logic [TAG_W-1:0] st_tag;
   line_st_t         st_val;
   cpu_op_t          op;

   assign op = cpu_op_t'(cpu_op);

   mei_clr_seq #(.IDX_W(IDX_W)) u_clr (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy    (busy),
      .clr_idx (clr_idx)
   );

   mei_arb #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_arb (
      .busy      (busy),
      .cpu_valid (cpu_valid),
      .cpu_addr  (cpu_addr),
      .snp_valid (snp_valid),
      .snp_addr  (snp_addr),
      .gnt_snp   (gnt_snp),
      .gnt_cpu   (gnt_cpu),
      .acc_idx   (acc_idx),
      .acc_tag   (acc_tag)
   );

   mei_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
      .clk    (clk),
      .we     (st_we),
      .idx    (st_idx),
      .wr_tag (st_tag),
      .wr_st  (st_val),
      .rd_tag (rd_tag),
      .rd_st  (rd_st)
   );

   assign match = (rd_tag == acc_tag) && (rd_st != LN_INV);

   mei_next_st u_nxt (
      .gnt_snp (gnt_snp),
      .gnt_cpu (gnt_cpu),
      .snp_inv (snp_inv),
      .op      (op),
      .match   (match),
      .cur     (rd_st),
      .upd     (upd),
      .new_tag (new_tag),
      .nxt     (nxt)
   );

   always_comb begin
      if (busy) begin
         st_we  = 1'b1;
         st_idx = clr_idx;
         st_tag = '0;
         st_val = LN_INV;
      end else begin
         st_we  = upd;
         st_idx = acc_idx;
         st_tag = new_tag ? acc_tag : rd_tag;
         st_val = nxt;
      end
   end

   always_comb begin
      stall     = busy | (cpu_valid & snp_valid);
      cpu_done  = gnt_cpu;
      cpu_hit   = gnt_cpu & match & ~cpu_op[1];
      cpu_evict = gnt_cpu & cpu_op[1] & (rd_st == LN_MOD);
      snp_done  = snp_valid;
      snp_hit   = gnt_snp & match;
      snp_wb    = gnt_snp & match & (rd_st == LN_MOD);
   end
endmodule

// File: rtl/mei_tag_ctrl_chk.sv
module mei_tag_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic cpu_valid,
   input logic snp_valid,
   input logic stall,
   input logic cpu_done,
   input logic cpu_hit,
   input logic snp_done,
   input logic snp_hit,
   input logic snp_wb
);
   logic held_q;

   always_ff @(posedge clk) begin
      if (!rst_n) held_q <= 1'b0;
      else        held_q <= cpu_valid & snp_valid & ~busy;
   end

   p_snoop_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && snp_valid) |-> (stall && !cpu_done));

   p_held_served_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q && cpu_valid && !snp_valid && !busy) |-> cpu_done);

   p_wb_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      snp_wb |-> (snp_hit && snp_done));

   p_sweep_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (stall && !cpu_done && !snp_hit));

   p_sweep_snoop_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && snp_valid) |-> (snp_done && !snp_wb));

   p_hit_needs_service_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hit |-> cpu_done);
endmodule

bind mei_tag_ctrl mei_tag_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .cpu_valid (cpu_valid),
   .snp_valid (snp_valid),
   .stall     (stall),
   .cpu_done  (cpu_done),
   .cpu_hit   (cpu_hit),
   .snp_done  (snp_done),
   .snp_hit   (snp_hit),
   .snp_wb    (snp_wb)
);

// File: tb/test_mei_tag_ctrl.sv
module test_mei_tag_ctrl;
   localparam int CLK_P  = 10;
   localparam int ADDR_W = 16;
   localparam int SETS   = 16;
   localparam int NV     = 22;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_valid = 1'b0;
   logic [1:0] cpu_op = 2'd0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic snp_valid = 1'b0;
   logic snp_inv = 1'b0;
   logic [ADDR_W-1:0] snp_addr = '0;
   logic stall, cpu_done, cpu_hit, cpu_evict, snp_done, snp_hit, snp_wb;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   mei_tag_ctrl #(.ADDR_W(ADDR_W), .OFF_W(4), .IDX_W(4)) i_mei_tag_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
      .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_addr(snp_addr),
      .stall(stall), .cpu_done(cpu_done), .cpu_hit(cpu_hit),
      .cpu_evict(cpu_evict), .snp_done(snp_done), .snp_hit(snp_hit),
      .snp_wb(snp_wb)
   );

   // vector: {is_snoop, op(cpu op / bit0=invalidate), addr, exp_hit, exp_flag}
   // exp_flag is cpu_evict for processor rows, snp_wb for snoop rows
   localparam logic [20:0] VEC [NV] = '{
      {1'b0, 2'd0, 16'h1230, 1'b0, 1'b0},  // R1 load after sweep misses
      {1'b0, 2'd2, 16'h1230, 1'b0, 1'b0},  // R3 fill-load, clean victim
      {1'b0, 2'd0, 16'h1230, 1'b1, 1'b0},  // R2 load hit
      {1'b0, 2'd0, 16'h123F, 1'b1, 1'b0},  // R10 offset ignored
      {1'b0, 2'd0, 16'h5230, 1'b0, 1'b0},  // R10 other tag same index
      {1'b0, 2'd1, 16'h1230, 1'b1, 1'b0},  // R4 store hit on exclusive
      {1'b1, 2'd0, 16'h1230, 1'b1, 1'b1},  // R4/R6 snoop read sees modified
      {1'b1, 2'd0, 16'h1230, 1'b1, 1'b0},  // R6/R7 now exclusive, read -> invalid
      {1'b0, 2'd0, 16'h1230, 1'b0, 1'b0},  // R7 line gone
      {1'b0, 2'd3, 16'h1230, 1'b0, 1'b0},  // R3 fill-store
      {1'b1, 2'd1, 16'h1230, 1'b1, 1'b1},  // R3/R6 invalidate modified
      {1'b0, 2'd0, 16'h1230, 1'b0, 1'b0},  // R6 invalidated
      {1'b0, 2'd2, 16'h0040, 1'b0, 1'b0},  // R3 fill-load idx 4
      {1'b1, 2'd1, 16'h0040, 1'b1, 1'b0},  // R7 invalidate exclusive
      {1'b0, 2'd0, 16'h0040, 1'b0, 1'b0},  // R7 gone
      {1'b0, 2'd3, 16'h0050, 1'b0, 1'b0},  // R3 fill-store idx 5
      {1'b0, 2'd2, 16'h7750, 1'b0, 1'b1},  // R9 fill over modified
      {1'b0, 2'd0, 16'h7750, 1'b1, 1'b0},  // R9 new tag present
      {1'b1, 2'd0, 16'h0060, 1'b0, 1'b0},  // R8 snoop miss
      {1'b0, 2'd0, 16'h0060, 1'b0, 1'b0},  // R8 nothing created
      {1'b1, 2'd1, 16'h9750, 1'b0, 1'b0},  // R8 miss on other tag
      {1'b0, 2'd0, 16'h7750, 1'b1, 1'b0}   // R8 line untouched
   };

   task automatic chk(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   initial begin : watchdog
      #(CLK_P * 5000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      int cnt;
      repeat (3) @(negedge clk);
      rst_n     = 1'b1;
      cpu_valid = 1'b1;
      cpu_op    = 2'd0;
      cpu_addr  = 16'h0010;
      snp_valid = 1'b1;
      snp_addr  = 16'h0010;
      #1;
      chk("R1 no service in sweep", cpu_done, 1'b0);
      chk("R8 snoop answered in sweep", snp_done, 1'b1);
      chk("R8 snoop miss in sweep", snp_hit, 1'b0);
      snp_valid = 1'b0;
      cnt = 0;
      while (stall) begin
         cnt++;
         @(negedge clk);
         #1;
      end
      n_run++;
      if (cnt != SETS) begin
         n_fail++;
         $display("FAIL R1 stall length: actual %0d expected %0d", cnt, SETS);
      end
      cpu_valid = 1'b0;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         cpu_valid = ~VEC[i][20];
         snp_valid = VEC[i][20];
         cpu_op    = VEC[i][19:18];
         snp_inv   = VEC[i][18];
         cpu_addr  = VEC[i][17:2];
         snp_addr  = VEC[i][17:2];
         #1;
         if (VEC[i][20]) begin
            chk($sformatf("R6/R7/R8 vec%0d snp_hit", i), snp_hit, VEC[i][1]);
            chk($sformatf("R6/R7/R8 vec%0d snp_wb", i), snp_wb, VEC[i][0]);
         end else begin
            chk($sformatf("R2/R3/R10 vec%0d cpu_done", i), cpu_done, 1'b1);
            chk($sformatf("R2/R3/R10 vec%0d cpu_hit", i), cpu_hit, VEC[i][1]);
            chk($sformatf("R9 vec%0d cpu_evict", i), cpu_evict, VEC[i][0]);
         end
      end

      // R5 collision: snoop invalidate and load on the same line
      @(negedge clk);
      snp_valid = 1'b0;
      cpu_valid = 1'b1; cpu_op = 2'd2; cpu_addr = 16'h0080;
      @(negedge clk);
      cpu_op = 2'd0;
      snp_valid = 1'b1; snp_inv = 1'b1; snp_addr = 16'h0080;
      #1;
      chk("R5 stall on collision", stall, 1'b1);
      chk("R5 processor held", cpu_done, 1'b0);
      chk("R5 snoop served first", snp_hit, 1'b1);
      @(negedge clk);
      snp_valid = 1'b0;
      #1;
      chk("R5 held load served", cpu_done, 1'b1);
      chk("R5 load sees invalidated line", cpu_hit, 1'b0);
      chk("R5 stall released", stall, 1'b0);
      @(negedge clk);
      cpu_valid = 1'b0;

      // R1 reset again in the middle of traffic: all lines invalid
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (SETS) @(negedge clk);
      cpu_valid = 1'b1; cpu_op = 2'd0; cpu_addr = 16'h7750;
      #1;
      chk("R1 served after sweep", cpu_done, 1'b1);
      chk("R1 line cleared by sweep", cpu_hit, 1'b0);
      @(negedge clk);
      cpu_valid = 1'b0;

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule